// File: doc/BRIEF.md
# Frequency Sweep and Lock Supervisor

This block oversees frequency acquisition for a clock recovery loop. It watches a sampled digital copy of the loop's frequency integrator. When no input carrier is present, the integrator drifts until it pins against one of its two limits. The block therefore treats a value held near either limit as loss of carrier. A value held away from both limits means a carrier is present.

Until phase lock is reported, the block requests a sweep. The sweep is a fixed signed step per cycle, which the integrator adds at its summing node. The sweep heads downward when the integrator reaches its upper limit and upward when it reaches its lower limit, so the search covers the whole range. Once phase lock is seen the sweep stops and the direction is held. If lock is lost, the search resumes in the direction it last used.

The lock indicator is the AND of carrier presence and the registered phase-lock flag. The block has no bypass input, so nothing outside these inputs can affect the lock indicator.

Top module: `sweep_lock_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, sweep_en is 1, sweep_up is 1 (upward), carrier_ok is 0 and lock_out is 0.
- R2: When integ stays at or above the upper threshold (largest value minus MARGIN) for HOLD consecutive sampled cycles, carrier_ok falls after the HOLD-th clock edge.
- R3: An excursion into either margin that lasts fewer than HOLD cycles leaves carrier_ok unchanged. HOLD consecutive cycles at or below the lower threshold (smallest value plus MARGIN) clear carrier_ok.
- R4: With carrier_ok low, HOLD consecutive cycles with integ strictly between the two thresholds set carrier_ok after the HOLD-th edge.
- R5: lock_out equals carrier_ok AND the value phase_lock had at the previous clock edge.
- R6: sweep_en is low in the cycle after an edge at which phase_lock is high, and high in the cycle after an edge at which it is low. While sweep_en is low, sweep_step is 0.
- R7: While sweep_en is high, sweep_step is +STEP when sweep_up is 1 and -STEP when sweep_up is 0.
- R8: While sweeping, an edge that samples integ at or above the upper threshold clears sweep_up. An edge that samples integ at or below the lower threshold sets sweep_up.
- R9: While sweep_en is low, sweep_up is held regardless of integ. When sweeping resumes, it continues in that held direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| integ | input | IW | Signed integrator value |
| phase_lock | input | 1 | Phase lock flag from the lock detector |
| sweep_en | output | 1 | Sweep requested |
| sweep_up | output | 1 | Sweep direction, 1 for up |
| sweep_step | output | IW | Signed sweep contribution per cycle |
| carrier_ok | output | 1 | Carrier judged present |
| lock_out | output | 1 | Overall lock indicator |

## Verification
The embedded properties check every cycle that:
- lock_out never rises without the previous phase-lock sample;
- sweep_en follows the inverse of the previous phase-lock sample;
- the direction turns at the correct rail, and never changes while sweeping is halted;
- carrier_ok moves only in agreement with where the integrator was last sampled.

Other behaviours can only be shown by the directed scenarios:
- the exact HOLD-cycle filtering;
- rejection of a short excursion;
- the signed step values;
- resuming the sweep in the held direction after lock is lost.

// File: rtl/sweep_lock_ctrl.sv
module sweep_lock_ctrl #(
  parameter int IW     = 12,
  parameter int MARGIN = 16,
  parameter int HOLD   = 4,
  parameter int STEP   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] integ,
  input  logic                 phase_lock,
  output logic                 sweep_en,
  output logic                 sweep_up,
  output logic signed [IW-1:0] sweep_step,
  output logic                 carrier_ok,
  output logic                 lock_out
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic signed [IW-1:0] TOP   = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] BOT   = {1'b1, {(IW-1){1'b0}}};
  localparam logic signed [IW-1:0] TH_HI = TOP - IW'(MARGIN);
  localparam logic signed [IW-1:0] TH_LO = BOT + IW'(MARGIN);
  localparam logic signed [IW-1:0] STP   = IW'(STEP);

  logic          pl_q;
  logic [CW-1:0] cnt;
  logic          near_hi, near_lo, at_rail, mismatch;

  assign near_hi  = integ >= TH_HI;
  assign near_lo  = integ <= TH_LO;
  assign at_rail  = near_hi | near_lo;
  assign mismatch = carrier_ok ? at_rail : !at_rail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_q       <= 1'b0;
      sweep_up   <= 1'b1;
      carrier_ok <= 1'b0;
      cnt        <= '0;
    end else begin
      pl_q <= phase_lock;
      if (!pl_q) begin
        if (near_hi)      sweep_up <= 1'b0;
        else if (near_lo) sweep_up <= 1'b1;
      end
      if (!mismatch) begin
        cnt <= '0;
      end else if (cnt == CW'(HOLD - 1)) begin
        cnt        <= '0;
        carrier_ok <= !carrier_ok;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sweep_en   = !pl_q;
  assign lock_out   = carrier_ok & pl_q;
  assign sweep_step = !sweep_en ? '0 : (sweep_up ? STP : -STP);

  // R5
  lock_needs_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_out |-> $past(phase_lock));
  // R6
  sweep_follows_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en == !$past(phase_lock));
  // R8
  turn_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sweep_en) && $past(integ) >= TH_HI) |-> !sweep_up);
  // R8
  turn_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sweep_en) && $past(integ) <= TH_LO) |-> sweep_up);
  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sweep_en) |-> $stable(sweep_up));
  // R4
  carrier_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_ok) |-> ($past(integ) < TH_HI && $past(integ) > TH_LO));
  // R2
  carrier_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_ok) |-> ($past(integ) >= TH_HI || $past(integ) <= TH_LO));
endmodule

// File: tb/sweep_lock_ctrl_bench.sv
module sweep_lock_ctrl_bench;
  localparam int IW = 12;
  localparam int STEP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [IW-1:0] integ = '0;
  logic phase_lock = 1'b0;
  logic sweep_en, sweep_up, carrier_ok, lock_out;
  logic signed [IW-1:0] sweep_step;
  int n_chk = 0, n_bad = 0;

  localparam logic signed [IW-1:0] HI  = 12'sd2040;
  localparam logic signed [IW-1:0] LO  = -12'sd2040;
  localparam logic signed [IW-1:0] MID = 12'sd0;

  sweep_lock_ctrl #(.IW(IW), .MARGIN(16), .HOLD(4), .STEP(STEP)) u_sweep_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .integ(integ), .phase_lock(phase_lock),
    .sweep_en(sweep_en), .sweep_up(sweep_up), .sweep_step(sweep_step),
    .carrier_ok(carrier_ok), .lock_out(lock_out));

  always #10 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R1 sweep_en", sweep_en, 1);
    chk("R1 sweep_up", sweep_up, 1);
    chk("R1 carrier", carrier_ok, 0);
    chk("R1 lock", lock_out, 0);
    rst_n = 1'b1;
    integ = MID;
    cyc(1);
    chk("R1 carrier after release", carrier_ok, 0);
    chk("R7 step up", sweep_step, STEP);
    cyc(2);
    chk("R4 carrier before HOLD", carrier_ok, 0);
    cyc(1);
    chk("R4 carrier restored", carrier_ok, 1);
  endtask

  task automatic t_upper_rail;
    integ = HI;
    cyc(1);
    chk("R8 turn down", sweep_up, 0);
    chk("R7 step down", sweep_step, -STEP);
    cyc(2);
    chk("R2 carrier before HOLD", carrier_ok, 1);
    cyc(1);
    chk("R2 carrier lost", carrier_ok, 0);
    integ = MID;
    cyc(4);
    chk("R4 carrier back", carrier_ok, 1);
  endtask

  task automatic t_lower_rail;
    integ = LO;
    cyc(3);
    chk("R8 turn up", sweep_up, 1);
    integ = MID;
    cyc(2);
    chk("R3 short excursion ignored", carrier_ok, 1);
    integ = LO;
    cyc(4);
    chk("R3 carrier lost at lower", carrier_ok, 0);
    integ = MID;
    cyc(4);
    chk("R4 carrier back", carrier_ok, 1);
  endtask

  task automatic t_lock;
    phase_lock = 1'b1;
    cyc(1);
    chk("R6 sweep off", sweep_en, 0);
    chk("R6 step zero", sweep_step, 0);
    chk("R5 lock high", lock_out, 1);
    integ = HI;
    cyc(1);
    integ = MID;
    cyc(1);
    chk("R9 dir held", sweep_up, 1);
    chk("R5 lock kept", lock_out, 1);
    integ = HI;
    cyc(4);
    chk("R5 lock needs carrier", lock_out, 0);
    chk("R9 dir held on rail", sweep_up, 1);
    integ = MID;
    cyc(4);
    chk("R5 lock back", lock_out, 1);
    phase_lock = 1'b0;
    cyc(1);
    chk("R6 sweep on", sweep_en, 1);
    chk("R5 lock low", lock_out, 0);
    chk("R9 resume up", sweep_step, STEP);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_upper_rail();
        t_lower_rail();
        t_lock();
      end
      begin
        cyc(5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule